// File: doc/BRIEF.md
# Pushbutton and Power-Fail Reset Controller

This block drives a single shared, active-low, open-drain reset line and also listens to it. The pin is split into a drive-enable output, which pulls the line low when high, and a sense input that returns the line level after the external pull-up. A power-fail comparator input reports whether the main supply is above its threshold. While it is not, the line is held low. When the supply comes back, the line stays low for a recovery hold-off, unless the oscillator is reported stopped. In that case the line is released straight away.

When no reset cycle is running, the controller watches the line for a falling edge from a pushbutton. On that edge it pulls the line low itself for a fixed debounce time. It then lets go and samples the line once. If the button is still down, the controller waits for release and then issues a fixed-length reset pulse. Every interval is counted in periods of a slow tick input, so the same logic works with any tick rate. A power-fail condition overrides any pushbutton activity. While the supply is low, the line is never watched.

Top module: `pbr_reset_ctrl`

## Requirements
- R1: A synchronous reset leaves the controller idle with the drive-enable low.
- R2: In the idle state, a falling edge on the sense input raises the drive-enable from the next clock cycle for exactly DEBOUNCE_TICKS tick periods.
- R3: After the debounce interval the drive-enable is low for one sample cycle. If the sense input is high in that cycle, the controller returns to idle and issues no pulse.
- R4: If the sense input is low in the sample cycle, the controller waits. On the first cycle the sense input is high again, it raises the drive-enable from the next cycle for exactly PULSE_TICKS tick periods, then returns to idle.
- R5: Whenever the supply-ok input is low, the drive-enable is high from the next cycle. This overrides and aborts any pushbutton sequence, and no edge on the line is acted on while the supply is low.
- R6: When the supply-ok input returns high while the oscillator-running input is high, the drive-enable stays high for RECOVER_TICKS tick periods after the return, then falls.
- R7: When the supply-ok input returns high while the oscillator-running input is low, the drive-enable falls on the next cycle.
- R8: The controller's own drive is masked out of edge detection. The end of any drive interval with the button up starts no new sequence.
- R9: All intervals count tick periods, not clock cycles. An interval ends on the clock edge carrying its Nth tick after the interval starts; a tick on the starting edge does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle timing tick, e.g. one per millisecond |
| supply_ok_i | input | 1 | Power comparator: 1 = main supply above threshold |
| osc_run_i | input | 1 | 1 = oscillator running; selects the recovery hold-off |
| pin_sense_i | input | 1 | Level of the shared reset line (1 = high) |
| pin_drive_o | output | 1 | 1 = pull the shared reset line low |

## Verification
The bench builds the controller with DEBOUNCE_TICKS = 3, PULSE_TICKS = 4 and RECOVER_TICKS = 5. These intervals are short and distinct, so each measured run length points to one interval. With the tick high on every cycle, every button hold length from 1 to 12 cycles can be swept. This covers presses released inside the debounce, at the sample cycle, and on each later cycle, and it fixes the exact start cycle of the reset pulse. Supply drops of one to four cycles are also swept with the oscillator both running and stopped. Further runs abort a press in progress, press during a supply drop, and thin the tick to one in three cycles so that intervals are seen to count ticks.

// File: rtl/pbr_pkg.sv
package pbr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_DEBOUNCE = 3'd1,
    ST_CHECK    = 3'd2,
    ST_WAIT_REL = 3'd3,
    ST_PULSE    = 3'd4,
    ST_PFAIL    = 3'd5,
    ST_RECOVER  = 3'd6
  } pbr_state_e;

  function automatic int unsigned cnt_width(input int unsigned maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction

  function automatic logic drives_pin(input pbr_state_e st);
    return (st == ST_DEBOUNCE) || (st == ST_PULSE) ||
           (st == ST_PFAIL)    || (st == ST_RECOVER);
  endfunction

endpackage

// File: rtl/pbr_tick_timer.sv
// Down-counter in tick periods. done_o marks the edge carrying the last tick.
module pbr_tick_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                         cnt_q <= '0;
    else if (load_i)                 cnt_q <= len_i;
    else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = tick_i && (cnt_q == CW'(1));
endmodule

// File: rtl/pbr_pin_watch.sv
// Edge detector on the shared line; own drive forces the seen level high.
module pbr_pin_watch (
  input  logic clk,
  input  logic rst,
  input  logic sense_i,
  input  logic mask_i,
  output logic level_o,
  output logic fall_o,
  output logic rise_o
);
  logic prev_q;

  assign level_o = sense_i | mask_i;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= level_o;
  end

  assign fall_o = prev_q & ~level_o;
  assign rise_o = ~prev_q & level_o;
endmodule

// File: rtl/pbr_reset_ctrl.sv
module pbr_reset_ctrl
  import pbr_pkg::*;
#(
  parameter int unsigned DEBOUNCE_TICKS = 250,
  parameter int unsigned PULSE_TICKS    = 250,
  parameter int unsigned RECOVER_TICKS  = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic supply_ok_i,
  input  logic osc_run_i,
  input  logic pin_sense_i,
  output logic pin_drive_o
);
  localparam int unsigned MAX_A = (DEBOUNCE_TICKS > PULSE_TICKS) ? DEBOUNCE_TICKS : PULSE_TICKS;
  localparam int unsigned MAX_T = (MAX_A > RECOVER_TICKS) ? MAX_A : RECOVER_TICKS;
  localparam int unsigned CW    = cnt_width(MAX_T);
  localparam logic [CW-1:0] LEN_DEB = CW'(DEBOUNCE_TICKS);
  localparam logic [CW-1:0] LEN_PUL = CW'(PULSE_TICKS);
  localparam logic [CW-1:0] LEN_REC = CW'(RECOVER_TICKS);

  pbr_state_e    state_q, state_d;
  logic          drive_q;
  logic          seen_level, seen_fall, seen_rise;
  logic          tmr_load, tmr_done;
  logic [CW-1:0] tmr_len;

  pbr_pin_watch watch_i (
    .clk     (clk),
    .rst     (rst),
    .sense_i (pin_sense_i),
    .mask_i  (drive_q),
    .level_o (seen_level),
    .fall_o  (seen_fall),
    .rise_o  (seen_rise)
  );

  pbr_tick_timer #(.CW(CW)) timer_i (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick_i),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .done_o (tmr_done)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_len  = LEN_DEB;
    if (!supply_ok_i) begin
      state_d = ST_PFAIL;
    end else begin
      unique case (state_q)
        ST_IDLE: if (seen_fall) begin
          state_d  = ST_DEBOUNCE;
          tmr_load = 1'b1;
          tmr_len  = LEN_DEB;
        end
        ST_DEBOUNCE: if (tmr_done) state_d = ST_CHECK;
        ST_CHECK:    state_d = seen_level ? ST_IDLE : ST_WAIT_REL;
        ST_WAIT_REL: if (seen_rise) begin
          state_d  = ST_PULSE;
          tmr_load = 1'b1;
          tmr_len  = LEN_PUL;
        end
        ST_PULSE:    if (tmr_done) state_d = ST_IDLE;
        ST_PFAIL: if (osc_run_i) begin
          state_d  = ST_RECOVER;
          tmr_load = 1'b1;
          tmr_len  = LEN_REC;
        end else begin
          state_d = ST_IDLE;
        end
        ST_RECOVER:  if (tmr_done) state_d = ST_IDLE;
        default:     state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      drive_q <= 1'b0;
    end else begin
      state_q <= state_d;
      drive_q <= drives_pin(state_d);
    end
  end

  assign pin_drive_o = drive_q;
endmodule

// File: rtl/pbr_reset_ctrl_chk.sv
module pbr_reset_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic supply_ok_i,
  input logic osc_run_i,
  input logic pin_sense_i,
  input logic pin_drive_o
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> !pin_drive_o); // R1

  AST_PFAIL_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !supply_ok_i |=> pin_drive_o); // R5

  AST_FAST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (pin_drive_o && !$past(supply_ok_i) && supply_ok_i && !osc_run_i) |=> !pin_drive_o); // R7

  AST_QUIET_LINE: assert property (@(posedge clk) disable iff (rst)
    (supply_ok_i && pin_sense_i && $past(pin_sense_i) && !pin_drive_o && !$past(pin_drive_o))
      |=> !pin_drive_o); // R8
endmodule

bind pbr_reset_ctrl pbr_reset_ctrl_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .supply_ok_i (supply_ok_i),
  .osc_run_i   (osc_run_i),
  .pin_sense_i (pin_sense_i),
  .pin_drive_o (pin_drive_o)
);

// File: tb/pbr_reset_ctrl_tb.sv
module pbr_reset_ctrl_tb_top;
  localparam int DEB = 3;
  localparam int PUL = 4;
  localparam int REC = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic supply_ok = 1'b1;
  logic osc_run = 1'b1;
  logic button = 1'b0;
  logic sparse = 1'b0;
  logic drive;
  wire  sense = !(drive || button);

  int checks = 0;
  int errors = 0;
  int gcyc = 0;
  int runs, len1, len2, start2, ticks_hi;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    gcyc++;
    tick <= sparse ? (gcyc % 3 == 0) : 1'b1;
  end

  pbr_reset_ctrl #(
    .DEBOUNCE_TICKS (DEB),
    .PULSE_TICKS    (PUL),
    .RECOVER_TICKS  (REC)
  ) dut_i (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick),
    .supply_ok_i (supply_ok),
    .osc_run_i   (osc_run),
    .pin_sense_i (sense),
    .pin_drive_o (drive)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Inputs for edge k are set at the negedge before it; drive is sampled after it.
  task automatic observe(input int hold, input int fail_at, input int fail_len,
                         input bit osc, input int win);
    int prevd;
    runs = 0; len1 = 0; len2 = 0; start2 = -1; ticks_hi = 0; prevd = 0;
    for (int k = 0; k < win; k++) begin
      button    = (k < hold);
      supply_ok = !(k >= fail_at && k < fail_at + fail_len);
      osc_run   = osc;
      @(posedge clk);
      if (tick && prevd != 0) ticks_hi++;
      @(negedge clk);
      if (drive && prevd == 0) begin
        runs++;
        if (runs == 2) start2 = k;
      end
      if (drive) begin
        if (runs == 1) len1++;
        else if (runs == 2) len2++;
      end
      prevd = drive ? 1 : 0;
    end
    button = 1'b0; supply_ok = 1'b1; osc_run = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 drive during reset", int'(drive), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 drive after reset", int'(drive), 0);

    // R2 R3 R4 R8: sweep of button hold lengths, tick on every cycle
    for (int h = 1; h <= 12; h++) begin
      observe(h, 0, 0, 1'b1, 40);
      check("R2 debounce length", len1, DEB);
      if (h >= DEB + 2) begin
        check("R4 R8 run count", runs, 2);
        check("R4 pulse start", start2, h);
        check("R4 pulse length", len2, PUL);
      end else begin
        check("R3 R8 run count", runs, 1);
      end
    end

    // R5 R6 R7: supply drops with oscillator running or stopped
    for (int l = 1; l <= 4; l++) begin
      for (int o = 0; o <= 1; o++) begin
        observe(0, 0, l, o[0], 30);
        check("R5 pfail run count", runs, 1);
        if (o == 1) check("R6 recovery length", len1, l + REC);
        else        check("R7 fast release length", len1, l);
      end
    end

    // R5: drop during debounce aborts the press
    observe(2, 1, 2, 1'b1, 40);
    check("R5 abort run count", runs, 1);
    check("R5 abort length", len1, 3 + REC);

    // R5: press while supply is low is not acted on
    observe(2, 0, 4, 1'b0, 30);
    check("R5 press in pfail run count", runs, 1);
    check("R5 press in pfail length", len1, 4);

    // R9: sparse ticks, one in three cycles
    sparse = 1'b1;
    repeat (4) @(negedge clk);
    observe(30, 0, 0, 1'b1, 80);
    check("R9 run count", runs, 2);
    check("R9 ticks while driven", ticks_hi, DEB + PUL);
    check("R9 debounce longer than ticks", int'(len1 > DEB), 1);
    sparse = 1'b0;

    summary();
    $finish;
  end
endmodule